// File: doc/BRIEF.md
# Data Address Generation Unit

This unit produces the 16-bit data-memory address for each operand access of a 16-bit DSP core. Two addressing styles are supported. The paged style joins a 9-bit page register with a 7-bit offset from the instruction word. The register-based style uses one of eight 16-bit pointer registers, chosen by a 3-bit selector.

In the register-based style the selected register's present value goes out as the address. A dedicated adder then writes the register back in the same cycle, using one of several step rules. Two of these rules propagate the carry or borrow from the top bit downward. This walks the bit-reversed index sequences used by FFT butterflies. The same access can also switch the selector to a new register, and the old selector value is kept in a 3-bit backup register.

The unit also reports two flags for the selected register: whether it is nonzero, and whether it equals register 0. Loop branches test these flags. Explicit writes of the page register or of any pointer register come in through their own load ports.

Top module: `addr_gen_unit`

## Requirements
- R1: With `use_ptr` low, `addr` equals `{page, ofs}`: page register in bits 15:7, `ofs` in bits 6:0. A `page_we` pulse loads `page_din` at the clock edge.
- R2: With `use_ptr` high, `addr` equals the current value of the pointer register chosen by `sel`. This is the value before any update.
- R3: On a valid pointer access (`acc_en` and `use_ptr` both high), `step` code 0 or 7 leaves the register unchanged. Code 1 adds one and code 2 subtracts one, both modulo 2^16.
- R4: Code 3 adds register 0 to the selected register, and code 4 subtracts register 0 from it, both modulo 2^16.
- R5: Code 5 adds register 0 with the carry running from bit 15 toward bit 0. A carry out of bit 0 is dropped.
- R6: Code 6 subtracts register 0 with the borrow running from bit 15 toward bit 0. A borrow out of bit 0 is dropped.
- R7: A valid pointer access with `sel_we` high copies the old `sel` into `sel_bak` and loads `sel_din` into `sel`. The step update still goes to the register selected before the switch.
- R8: `ptr_we` writes `ptr_din` into register `ptr_wsel`. This write wins over a step update of the same register in the same cycle. An update of a different register in that cycle still happens.
- R9: `nz` is high exactly when the selected register is nonzero. `eq0` is high exactly when it equals register 0.
- R10: After reset, the page register, all pointer registers, `sel` and `sel_bak` are zero.
- R11: No pointer register or selector changes unless a valid pointer access or an explicit load happens. Paged accesses count as neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | An operand access happens this cycle |
| use_ptr | input | 1 | 1 = register-based address, 0 = paged address |
| ofs | input | 7 | Offset field for paged addressing |
| step | input | 3 | Update rule for register-based access |
| sel_we | input | 1 | Switch the selector on this access |
| sel_din | input | 3 | New selector value |
| page_we | input | 1 | Load the page register |
| page_din | input | 9 | New page value |
| ptr_we | input | 1 | Load a pointer register |
| ptr_wsel | input | 3 | Pointer register to load |
| ptr_din | input | 16 | Value to load |
| addr | output | 16 | Effective data address |
| nz | output | 1 | Selected register is nonzero |
| eq0 | output | 1 | Selected register equals register 0 |
| sel | output | 3 | Current selector |
| sel_bak | output | 3 | Saved previous selector |

## Verification
Two writes can fall on the same pointer register in the same cycle: an explicit load through the load port, and the step update of a register-based access. The bench provokes this by pulsing `ptr_we` for the selected register during an increment access. It checks that the loaded value, not the incremented one, is read back on the next access. A second case loads a different register during an update, and both writes must land. A selector switch in the same cycle as an update is also checked: the update must go to the register selected before the switch.

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 7,
  parameter int NPTR   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_en,
  input  logic                       use_ptr,
  input  logic [OFS_W-1:0]           ofs,
  input  logic [2:0]                 step,
  input  logic                       sel_we,
  input  logic [$clog2(NPTR)-1:0]    sel_din,
  input  logic                       page_we,
  input  logic [PAGE_W-1:0]          page_din,
  input  logic                       ptr_we,
  input  logic [$clog2(NPTR)-1:0]    ptr_wsel,
  input  logic [PAGE_W+OFS_W-1:0]    ptr_din,
  output logic [PAGE_W+OFS_W-1:0]    addr,
  output logic                       nz,
  output logic                       eq0,
  output logic [$clog2(NPTR)-1:0]    sel,
  output logic [$clog2(NPTR)-1:0]    sel_bak
);
  localparam int AW = PAGE_W + OFS_W;
  localparam int SW = $clog2(NPTR);

  logic [AW-1:0]     ptr [NPTR];
  logic [PAGE_W-1:0] page;
  logic [AW-1:0]     cur, idx, nxt;
  logic              upd;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    for (int b = 0; b < AW; b++) flip[b] = v[AW-1-b];
  endfunction

  assign cur  = ptr[sel];
  assign idx  = ptr[0];
  assign upd  = acc_en && use_ptr;
  assign addr = use_ptr ? cur : {page, ofs};
  assign nz   = |cur;
  assign eq0  = (cur == idx);

  always_comb begin
    case (step)
      3'd1:    nxt = cur + 1'b1;
      3'd2:    nxt = cur - 1'b1;
      3'd3:    nxt = cur + idx;
      3'd4:    nxt = cur - idx;
      3'd5:    nxt = flip(flip(cur) + flip(idx));
      3'd6:    nxt = flip(flip(cur) - flip(idx));
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page    <= '0;
      sel     <= '0;
      sel_bak <= '0;
      for (int i = 0; i < NPTR; i++) ptr[i] <= '0;
    end else begin
      if (page_we) page <= page_din;
      if (upd && sel_we) begin
        sel_bak <= sel;
        sel     <= sel_din;
      end
      for (int i = 0; i < NPTR; i++) begin
        if (ptr_we && ptr_wsel == SW'(i)) ptr[i] <= ptr_din;
        else if (upd && sel == SW'(i))    ptr[i] <= nxt;
      end
    end
  end

  // R1
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_we && !use_ptr |=> !use_ptr || addr[AW-1:OFS_W] == $past(page_din));

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && step == 3'd1 && !ptr_we |=> ptr[$past(sel)] == $past(cur) + 1'b1);

  // R7
  sel_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && sel_we |=> sel == $past(sel_din) && sel_bak == $past(sel));

  // R8
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> ptr[$past(ptr_wsel)] == $past(ptr_din));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd && !ptr_we |=> $stable(sel) && $stable(sel_bak) && ptr[sel] == $past(cur));
endmodule

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, use_ptr = 0, sel_we = 0, page_we = 0, ptr_we = 0;
  logic [6:0] ofs = 0;
  logic [2:0] step = 0, sel_din = 0, ptr_wsel = 0;
  logic [8:0] page_din = 0;
  logic [15:0] ptr_din = 0;
  logic [15:0] addr;
  logic nz, eq0;
  logic [2:0] sel, sel_bak;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_ptr [8];
  logic [8:0]  m_page;
  logic [2:0]  m_sel, m_bak;

  always #2 clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .use_ptr(use_ptr), .ofs(ofs),
    .step(step), .sel_we(sel_we), .sel_din(sel_din), .page_we(page_we),
    .page_din(page_din), .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_din(ptr_din),
    .addr(addr), .nz(nz), .eq0(eq0), .sel(sel), .sel_bak(sel_bak));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rc_add(input logic [15:0] a, input logic [15:0] b);
    logic c = 0;
    for (int i = 15; i >= 0; i--) begin
      rc_add[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
  endfunction

  function automatic logic [15:0] rc_sub(input logic [15:0] a, input logic [15:0] b);
    logic w = 0;
    for (int i = 15; i >= 0; i--) begin
      rc_sub[i] = a[i] ^ b[i] ^ w;
      w = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & w);
    end
  endfunction

  task automatic cyc(input string tag, input logic v, input logic p, input logic [6:0] o,
                     input logic [2:0] s, input logic sw, input logic [2:0] sn,
                     input logic pgw, input logic [8:0] pg,
                     input logic lw, input logic [2:0] ls, input logic [15:0] lv);
    logic [15:0] c, x, n;
    @(negedge clk);
    acc_en = v; use_ptr = p; ofs = o; step = s; sel_we = sw; sel_din = sn;
    page_we = pgw; page_din = pg; ptr_we = lw; ptr_wsel = ls; ptr_din = lv;
    #1;
    c = m_ptr[m_sel]; x = m_ptr[0];
    check({tag, " addr"}, addr, p ? c : {m_page, o});
    check({tag, " nz (R9)"}, {15'd0, nz}, {15'd0, c != 0});
    check({tag, " eq0 (R9)"}, {15'd0, eq0}, {15'd0, c == x});
    check({tag, " sel (R7)"}, {13'd0, sel}, {13'd0, m_sel});
    check({tag, " sel_bak (R7)"}, {13'd0, sel_bak}, {13'd0, m_bak});
    case (s)
      3'd1: n = c + 1; 3'd2: n = c - 1; 3'd3: n = c + x; 3'd4: n = c - x;
      3'd5: n = rc_add(c, x); 3'd6: n = rc_sub(c, x); default: n = c;
    endcase
    @(posedge clk); #0.5;
    if (v && p && !(lw && ls == m_sel)) m_ptr[m_sel] = n;
    if (lw) m_ptr[ls] = lv;
    if (pgw) m_page = pg;
    if (v && p && sw) begin m_bak = m_sel; m_sel = sn; end
  endtask

  task automatic ld(input logic [2:0] r, input logic [15:0] v);
    cyc("R8 load", 0, 0, 0, 0, 0, 0, 0, 0, 1, r, v);
  endtask
  task automatic acc(input string tag, input logic [2:0] s, input logic sw, input logic [2:0] sn);
    cyc(tag, 1, 1, 0, s, sw, sn, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    cyc("R10 reset", 0, 0, 7'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R10 reset ptr", 0, 0, 0);
  endtask

  task automatic t_direct;
    cyc("R1 page load", 1, 0, 7'h11, 0, 0, 0, 1, 9'h1A5, 0, 0, 0);
    cyc("R1 paged", 1, 0, 7'h3C, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1 page max", 1, 0, 7'h7F, 0, 0, 0, 1, 9'h1FF, 0, 0, 0);
    cyc("R1 paged max", 1, 0, 7'h7F, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    for (int i = 0; i < 8; i++) ld(3'(i), 16'(i * 16'h0111 + 3));
    for (int i = 1; i < 8; i++) acc("R2 read", 0, 1, 3'(i));
    acc("R2 read", 0, 1, 3'd5);
    acc("R3 inc", 1, 0, 0);
    acc("R3 dec", 2, 0, 0);
    acc("R3 code7", 7, 0, 0);
    acc("R3 code0", 0, 0, 0);
    ld(5, 16'hFFFF);
    acc("R3 inc wrap", 1, 0, 0);
    acc("R3 dec wrap", 2, 0, 0);
    acc("R3 after wrap", 0, 0, 0);
  endtask

  task automatic t_index;
    ld(0, 16'h0020); ld(3, 16'h0100);
    acc("R4 sel", 0, 1, 3);
    acc("R4 add", 3, 0, 0);
    acc("R4 add2", 3, 0, 0);
    acc("R4 sub", 4, 0, 0);
    ld(3, 16'h0010);
    acc("R4 sub wrap", 4, 0, 0);
    acc("R4 result", 0, 0, 0);
  endtask

  task automatic t_rev;
    ld(0, 16'h0008); ld(2, 16'h0000);
    acc("R5 sel", 0, 1, 2);
    for (int i = 0; i < 18; i++) acc("R5 rc add", 5, 0, 0);
    for (int i = 0; i < 18; i++) acc("R6 rc sub", 6, 0, 0);
    ld(0, 16'h0100); ld(2, 16'hFF00);
    for (int i = 0; i < 4; i++) acc("R5 rc add top", 5, 0, 0);
    ld(2, 16'h0000);
    for (int i = 0; i < 4; i++) acc("R6 rc sub under", 6, 0, 0);
  endtask

  task automatic t_ptr;
    ld(4, 16'h4444); ld(6, 16'h6666);
    acc("R7 to 4", 0, 1, 4);
    acc("R7 inc then to 6", 1, 1, 6);
    acc("R7 on 6", 0, 1, 4);
    acc("R7 old got inc", 0, 0, 0);
    cyc("R11 paged with sel_we", 1, 0, 7'h01, 1, 1, 3'd2, 0, 0, 0, 0, 0);
    acc("R11 sel held", 0, 0, 0);
  endtask

  task automatic t_collide;
    ld(1, 16'h1000);
    acc("R8 sel 1", 0, 1, 1);
    cyc("R8 same reg", 1, 1, 0, 1, 0, 0, 0, 0, 1, 3'd1, 16'hBEEF);
    acc("R8 load won", 0, 0, 0);
    cyc("R8 other reg", 1, 1, 0, 1, 0, 0, 0, 0, 1, 3'd7, 16'h7777);
    acc("R8 upd landed", 0, 1, 7);
    acc("R8 other landed", 0, 0, 0);
  endtask

  task automatic t_idle;
    acc("R11 sel 1", 0, 1, 1);
    cyc("R11 no access", 0, 1, 0, 1, 1, 3'd3, 0, 0, 0, 0, 0);
    cyc("R11 paged", 1, 0, 7'h05, 2, 0, 0, 0, 0, 0, 0, 0);
    acc("R11 unchanged", 0, 0, 0);
  endtask

  task automatic t_flags;
    ld(0, 16'h0042); ld(2, 16'h0000); ld(3, 16'h0042);
    acc("R9 zero reg", 0, 1, 2);
    acc("R9 equal reg", 0, 1, 3);
    acc("R9 sel 0", 0, 1, 0);
    acc("R9 self", 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_ptr[i] = 0;
    m_page = 0; m_sel = 0; m_bak = 0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    t_reset; t_direct; t_basic; t_index; t_rev; t_ptr; t_collide; t_idle; t_flags;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule